// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of a burst access to a synchronous DRAM bank. A controller pulses `start` together with the first column, the burst length code, the ordering choice and the read/write flag. From the next clock edge on, the block presents one column per enabled clock edge on `col`, qualified by `beat_valid`, and marks the final beat with `last_beat`.

Bursts of 1, 2, 4 and 8 beats wrap inside the aligned block of columns that their length defines. They follow either an incrementing order or an XOR order. A full-page burst runs through every column of the row, wrapping from the top column back to zero, until `burst_stop` or a new `start` arrives. A low clock enable freezes the generator one edge after it is sampled. When writes are programmed as single-beat, write bursts produce one beat while reads keep the programmed length. A reserved length code gives a one-beat burst and raises a flag that stays set until reset.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The length code `len_code` selects the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives a full page of 2^COL_W (256) beats.
- R2: With `interleave`=0, beat i carries column (start & ~(L-1)) | ((start + i) & (L-1)) for a burst of L beats. For example, start 5 with L=8 gives 5,6,7,0,1,2,3,4.
- R3: With `interleave`=1 and L of 2, 4 or 8, beat i carries column (start & ~(L-1)) | ((start ^ i) & (L-1)). For example, start 5 with L=8 gives 5,4,7,6,1,0,3,2.
- R4: A full-page burst always uses the incrementing order (`interleave` is ignored). It wraps from column 255 to 0, never asserts `last_beat`, and runs until stopped or restarted.
- R5: `burst_stop` sampled at an enabled edge without `start` drops `beat_valid` after that edge.
- R6: `cke` sampled low at edge N masks edge N+1. At a masked edge `col` and `beat_valid` hold and `start` is ignored. Edge N itself still acts.
- R7: With `wr_single`=1, a burst started with `is_write`=1 has one beat. A burst started with `is_write`=0 keeps the length given by `len_code`.
- R8: A reserved length code (3'b100, 3'b101, 3'b110) gives a one-beat burst and sets `cfg_err`, which stays 1 until reset.
- R9: A `start` accepted at an enabled edge presents `start_col` with `beat_valid`=1 after that edge. This holds even while a burst is running, and the old burst is abandoned.
- R10: After reset `beat_valid`, `last_beat` and `cfg_err` are 0 and `col` is 0.
- R11: `last_beat` is 1 only together with `beat_valid`, and only on the final beat of a fixed-length burst. At the next enabled edge without `start`, `beat_valid` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low masks the following edge |
| start | input | 1 | Begin a new burst with the settings below |
| is_write | input | 1 | The burst being started is a write |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 0 incrementing order, 1 XOR order |
| wr_single | input | 1 | Force write bursts to a single beat |
| burst_stop | input | 1 | Terminate the running burst |
| col | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A burst beat is being presented |
| last_beat | output | 1 | The current beat is the final one |
| cfg_err | output | 1 | Sticky flag: a reserved length code was used |

## Verification
Each result of an enabled edge is visible right after that edge: the first beat one edge after `start`, each later beat one edge after the previous one, and the drop of `beat_valid` one edge after the final beat or after `burst_stop`. The exception is the clock enable, which acts one edge later than it is sampled. The bench therefore drives inputs just after a rising edge and samples the outputs shortly after the next rising edge. When it lowers `cke`, it expects one more advance, and then a hold that lasts one edge longer than the low period.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    // Width of the burst length code field
    localparam int unsigned LEN_CODE_W = 3;
    // Highest code that selects a power-of-two burst (2^code beats)
    localparam logic [LEN_CODE_W-1:0] MAX_FIXED_CODE = 3'd3;
    // Code that selects a full-page burst
    localparam logic [LEN_CODE_W-1:0] FULL_PAGE_CODE = 3'd7;

    // Column ordering within a burst
    typedef enum logic {
        ORD_INCR = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;

    // Decoded shape of a burst
    typedef struct packed {
        logic full;      // full-page burst
        logic reserved;  // code was reserved
    } len_kind_t;
endpackage

// File: rtl/bcg_len_decode.sv
// Decodes the burst length code into a wrap mask (length minus one) and
// a kind. Assumes MAX_FIXED_CODE < COL_W. A forced single beat overrides the code.
module bcg_len_decode #(
    parameter int COL_W = 8
) (
    input  logic [bcg_pkg::LEN_CODE_W-1:0] len_code,
    input  logic                           force_single,
    output logic [COL_W-1:0]               mask,
    output bcg_pkg::len_kind_t             kind
);
    import bcg_pkg::*;

    logic [COL_W-1:0] pow_mask;

    // Mask of 2^code - 1 for the fixed power-of-two lengths
    always_comb begin
        for (int b = 0; b < COL_W; b++) begin
            pow_mask[b] = (b < int'(len_code));
        end
    end

    // Classify the code and select the final mask
    always_comb begin
        kind.reserved = 1'b0;
        kind.full     = 1'b0;
        mask          = '0;
        if (len_code <= MAX_FIXED_CODE) begin
            mask = pow_mask;
        end else if (len_code == FULL_PAGE_CODE) begin
            kind.full = 1'b1;
            mask      = '1;
        end else begin
            kind.reserved = 1'b1;
        end
        if (force_single) begin
            kind.full = 1'b0;
            mask      = '0;
        end
    end
endmodule

// File: rtl/bcg_order.sv
// Forms the column of beat idx from the latched start column. Bits above
// the mask come from the start; bits inside it are incremented or XORed.
// Assumes mask is a contiguous low run of ones.
module bcg_order #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  bcg_pkg::order_e  order,
    input  logic             full,
    output logic [COL_W-1:0] col
);
    import bcg_pkg::*;

    logic [COL_W-1:0] incr_low;
    logic [COL_W-1:0] xor_low;
    logic             use_xor;

    // Both candidate low parts, confined to the wrap window
    always_comb begin
        incr_low = (base_col + idx) & mask;
        xor_low  = (base_col ^ idx) & mask;
    end

    // Full page forces the incrementing order
    always_comb use_xor = (order == ORD_XOR) && !full;

    // Merge the fixed high bits with the selected low bits
    always_comb col = (base_col & ~mask) | (use_xor ? xor_low : incr_low);
endmodule

// File: rtl/bcg_beat_ctrl.sv
// Holds the burst state: latched settings, beat index and activity.
// Applies the one-edge clock-enable delay. At an enabled edge, start beats
// stop, which beats normal advance.
module bcg_beat_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic             burst_stop,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] mask_in,
    input  logic             full_in,
    input  bcg_pkg::order_e  order_in,
    output logic             edge_en,
    output logic             active,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] idx_q,
    output logic [COL_W-1:0] mask_q,
    output logic             full_q,
    output bcg_pkg::order_e  order_q,
    output logic             last
);
    import bcg_pkg::*;

    localparam logic [COL_W-1:0] IDX_ONE = 1;

    // Delay the clock enable by one edge
    always_ff @(posedge clk) begin
        if (!rst_n) edge_en <= 1'b1;
        else        edge_en <= cke;
    end

    // Final beat of a fixed-length burst
    always_comb last = active && !full_q && (idx_q == mask_q);

    // Burst state update on enabled edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            base_q  <= '0;
            idx_q   <= '0;
            mask_q  <= '0;
            full_q  <= 1'b0;
            order_q <= ORD_INCR;
        end else if (edge_en) begin
            if (start) begin
                active  <= 1'b1;
                base_q  <= start_col;
                idx_q   <= '0;
                mask_q  <= mask_in;
                full_q  <= full_in;
                order_q <= order_in;
            end else if (burst_stop) begin
                active <= 1'b0;
            end else if (active) begin
                if (last) active <= 1'b0;
                else      idx_q  <= idx_q + IDX_ONE;
            end
        end
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
// Top of the burst column generator. Decodes the length on the live
// inputs, latches it at start, and forms the column of every beat.
// Keeps a sticky flag for reserved length codes.
module sdram_burst_colgen #(
    parameter int COL_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cke,
    input  logic                           start,
    input  logic                           is_write,
    input  logic [COL_W-1:0]               start_col,
    input  logic [bcg_pkg::LEN_CODE_W-1:0] len_code,
    input  logic                           interleave,
    input  logic                           wr_single,
    input  logic                           burst_stop,
    output logic [COL_W-1:0]               col,
    output logic                           beat_valid,
    output logic                           last_beat,
    output logic                           cfg_err
);
    import bcg_pkg::*;

    logic [COL_W-1:0] dec_mask;
    len_kind_t        dec_kind;
    logic             edge_en;
    logic             active;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    order_e           order_q;
    order_e           order_in;
    logic             last;

    // Ordering request from the pin
    always_comb order_in = interleave ? ORD_XOR : ORD_INCR;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code     (len_code),
        .force_single (is_write && wr_single),
        .mask         (dec_mask),
        .kind         (dec_kind)
    );

    bcg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .start      (start),
        .burst_stop (burst_stop),
        .start_col  (start_col),
        .mask_in    (dec_mask),
        .full_in    (dec_kind.full),
        .order_in   (order_in),
        .edge_en    (edge_en),
        .active     (active),
        .base_q     (base_q),
        .idx_q      (idx_q),
        .mask_q     (mask_q),
        .full_q     (full_q),
        .order_q    (order_q),
        .last       (last)
    );

    bcg_order #(.COL_W(COL_W)) u_ord (
        .base_col (base_q),
        .idx      (idx_q),
        .mask     (mask_q),
        .order    (order_q),
        .full     (full_q),
        .col      (col)
    );

    // Sticky flag, set when a start is accepted with a reserved code
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cfg_err <= 1'b0;
        else if (edge_en && start && dec_kind.reserved) cfg_err <= 1'b1;
    end

    // Beat qualifiers
    always_comb begin
        beat_valid = active;
        last_beat  = last;
    end
endmodule

// File: rtl/bcg_checker.sv
// Temporal checks on the burst column generator ports. Keeps its own copy
// of the delayed clock enable.
module bcg_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             start,
    input logic             burst_stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col,
    input logic             beat_valid,
    input logic             last_beat,
    input logic             cfg_err
);
    logic cke_d;

    // Delayed enable as seen by the generator
    always_ff @(posedge clk) begin
        if (!rst_n) cke_d <= 1'b1;
        else        cke_d <= cke;
    end

    a_r11_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> beat_valid);

    a_r11_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && cke_d && !start) |=> !beat_valid);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r5_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !start && cke_d) |=> !beat_valid);

    a_r9_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cke_d) |=> (beat_valid && col == $past(start_col)));

    a_r6_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ##1 ($stable(col) && $stable(beat_valid)));
endmodule

bind sdram_burst_colgen bcg_checker #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .start      (start),
    .burst_stop (burst_stop),
    .start_col  (start_col),
    .col        (col),
    .beat_valid (beat_valid),
    .last_beat  (last_beat),
    .cfg_err    (cfg_err)
);

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       start = 1'b0;
    logic       is_write = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       interleave = 1'b0;
    logic       wr_single = 1'b0;
    logic       burst_stop = 1'b0;
    logic [7:0] col;
    logic       beat_valid;
    logic       last_beat;
    logic       cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdram_burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start), .is_write(is_write),
        .start_col(start_col), .len_code(len_code), .interleave(interleave),
        .wr_single(wr_single), .burst_stop(burst_stop), .col(col),
        .beat_valid(beat_valid), .last_beat(last_beat), .cfg_err(cfg_err)
    );

    // Advance one edge and settle just after it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int i, input int len, input bit xo);
        int m;
        m = len - 1;
        return (s & ~m & 255) | (xo ? ((s ^ i) & m) : ((s + i) & m));
    endfunction

    // Start a burst and check every beat; fixed bursts also check the end
    task automatic run_burst(input string tag, input int s, input int code, input bit wr,
                             input bit single, input bit inter, input int beats,
                             input int len, input bit xo, input bit full);
        start_col = 8'(s); len_code = 3'(code); is_write = wr;
        wr_single = single; interleave = inter; start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < beats; i++) begin
            if (i > 0) tick();
            chk({tag, " col"}, int'(col), exp_col(s, i, len, xo));
            chk({tag, " valid"}, int'(beat_valid), 1);
            chk({tag, " last"}, int'(last_beat), (!full && i == beats - 1) ? 1 : 0);
        end
        if (!full) begin
            tick();
            chk({tag, " R11 ends"}, int'(beat_valid), 0);
        end
    endtask

    task automatic t_reset();
        chk("R10 valid", int'(beat_valid), 0);
        chk("R10 last", int'(last_beat), 0);
        chk("R10 err", int'(cfg_err), 0);
        chk("R10 col", int'(col), 0);
    endtask

    task automatic t_lengths();
        run_burst("R1 len1", 6, 0, 0, 0, 0, 1, 1, 0, 0);
        run_burst("R1 len2", 6, 1, 0, 0, 0, 2, 2, 0, 0);
        run_burst("R2 len4 seq", 7, 2, 0, 0, 0, 4, 4, 0, 0);
        run_burst("R2 len8 seq", 5, 3, 0, 0, 0, 8, 8, 0, 0);
    endtask

    task automatic t_interleave();
        run_burst("R3 len8 xor", 5, 3, 0, 0, 1, 8, 8, 1, 0);
        run_burst("R3 len4 xor", 7, 2, 0, 0, 1, 4, 4, 1, 0);
        run_burst("R3 len2 xor", 1, 1, 0, 0, 1, 2, 2, 1, 0);
    endtask

    task automatic t_full_page_stop();
        run_burst("R4 full wrap", 250, 7, 0, 0, 1, 10, 256, 0, 1);
        burst_stop = 1'b1;
        tick();
        burst_stop = 1'b0;
        chk("R5 stop valid", int'(beat_valid), 0);
        tick();
        chk("R5 stays idle", int'(beat_valid), 0);
    endtask

    task automatic t_cke();
        start_col = 8'd0; len_code = 3'd3; interleave = 1'b0; is_write = 1'b0;
        wr_single = 1'b0; start = 1'b1;
        tick();
        start = 1'b0;
        tick();
        tick();
        chk("R6 pre col", int'(col), 2);
        cke = 1'b0;
        tick();
        chk("R6 latency edge", int'(col), 3);
        tick();
        chk("R6 frozen col", int'(col), 3);
        chk("R6 frozen valid", int'(beat_valid), 1);
        cke = 1'b1; start = 1'b1; start_col = 8'd100;
        tick();
        start = 1'b0;
        chk("R6 start ignored", int'(col), 3);
        tick();
        chk("R6 resumes", int'(col), 4);
        burst_stop = 1'b1;
        tick();
        burst_stop = 1'b0;
        chk("R5 stop mid", int'(beat_valid), 0);
    endtask

    task automatic t_write_single();
        run_burst("R7 write single", 3, 3, 1, 1, 0, 1, 1, 0, 0);
        run_burst("R7 read keeps len", 3, 3, 0, 1, 0, 8, 8, 0, 0);
        run_burst("R7 write normal", 3, 2, 1, 0, 0, 4, 4, 0, 0);
    endtask

    task automatic t_reserved();
        run_burst("R8 reserved len1", 9, 4, 0, 0, 0, 1, 1, 0, 0);
        chk("R8 err set", int'(cfg_err), 1);
        run_burst("R8 after valid code", 12, 1, 0, 0, 0, 2, 2, 0, 0);
        chk("R8 err sticky", int'(cfg_err), 1);
    endtask

    task automatic t_restart();
        start_col = 8'd0; len_code = 3'd3; interleave = 1'b0; start = 1'b1;
        tick();
        start = 1'b0;
        tick();
        chk("R9 first burst", int'(col), 1);
        run_burst("R9 restart", 20, 2, 0, 0, 0, 4, 4, 0, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_lengths();
        t_interleave();
        t_full_page_stop();
        t_cke();
        t_write_single();
        t_restart();
        t_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule